// File: doc/BRIEF.md
# Write-and-Invalidate Admission Controller

This block sits on the target side of a bus bridge that posts memory writes into a byte-wide queue. It does not move data. For every data phase the initiator offers, it decides whether the bridge takes the phase, retries the request, or disconnects without data. It also picks the command that the outbound side must use for that phase: a plain memory write or a memory write and invalidate (MWI).

A full MWI keeps its command only when four conditions hold: the programmed line size is legal, posting is on, aliasing is off, and the burst starts on a line boundary. Such a burst reserves queue space one whole cacheline at a time, and the reservation is checked again at every line boundary. Any other MWI is handled as a plain memory write. Plain memory writes are admitted one phase at a time, as long as the queue is not full. Outbound events can change the command or the response for the rest of a burst: a target disconnect or a master abort.

The line size register counts 32-bit words, so one line is the register value times four bytes. Each data phase moves one 4-byte word.

Top module: `wmi_admit`

## Requirements
- R1: A start phase of a qualifying MWI (line size 8 or 16, posting on, alias off, aligned start) is accepted with outbound command MWI (code 2) if free_bytes_i is at least the line size in bytes (32 or 64). Otherwise it is retried and no transaction opens.
- R2: Inside a qualifying MWI burst, phases within a line are accepted without a space check. The first phase of each new line is accepted only if free_bytes_i is at least the line size in bytes. Otherwise that phase is disconnected and the burst ends.
- R3: An MWI with a line size register value other than 8 or 16 is handled as a plain memory write (code 1).
- R4: With posting disabled, an MWI is handled as a plain memory write (code 1). Only the first data phase is accepted, and the next phase of that transaction is disconnected.
- R5: With the alias bit set, an MWI start is accepted whenever q_full_i is low, whatever the free space. It is forwarded with code 1.
- R6: An MWI whose start address is not a multiple of the line size in bytes is forwarded as a plain memory write (code 1).
- R7: An initiator end (end_i) closes the transaction. Phases of a partial MWI line accepted before the end keep code 2. Later phases without start_i get no response.
- R8: A target disconnect (tgt_disc_i) in the middle of an MWI line makes the rest of that line's accepted phases use code 1. The next line returns to code 2.
- R9: After a master abort (mabort_i) in an open transaction, its next data phase is disconnected and the transaction ends.
- R10: A plain memory write phase is accepted with code 1 while q_full_i is low. When q_full_i is high, a start phase is retried and a later phase is disconnected.
- R11: Responses are one-hot and registered. They appear in the cycle after the phase_i strobe and are idle (all low, code 0) after reset and after any cycle without phase_i. The code is nonzero exactly when accept_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_i | input | 1 | Initiator offers a data phase this cycle |
| start_i | input | 1 | The offered phase is the first of a transaction |
| end_i | input | 1 | Initiator ended the transaction |
| mwi_i | input | 1 | Transaction command is MWI (else memory write) |
| addr_lo_i | input | 6 | Low byte-address bits of the start address |
| cls_i | input | 8 | Cacheline size register, in 32-bit words |
| free_bytes_i | input | 10 | Free bytes in the posted-write queue |
| q_full_i | input | 1 | Posted-write queue is full |
| post_en_i | input | 1 | Write posting enabled |
| alias_en_i | input | 1 | Alias MWI to memory write |
| tgt_disc_i | input | 1 | Outbound target disconnected |
| mabort_i | input | 1 | Outbound transaction master-aborted |
| accept_o | output | 1 | Phase accepted |
| retry_o | output | 1 | Request retried |
| disc_o | output | 1 | Disconnect without data |
| out_cmd_o | output | 2 | Outbound command: 0 none, 1 memory write, 2 MWI |

## Verification
A wrong line offset shows up as a space check on the wrong phase. That gives either a disconnect in the middle of a line or an acceptance at a boundary with too little space, and it appears within one line of phases (8 or 16). A stale mode flag turns the outbound code from 2 to 1 or back on the very next accepted phase. A stuck abort or single-phase flag gives a disconnect on the following phase where an accept is expected. Because every phase response is compared one cycle after its strobe, each such fault is caught no later than the next line boundary.

// File: rtl/wmi_pkg.sv
package wmi_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_MW   = 2'd1,
    CMD_MWI  = 2'd2
  } out_cmd_e;
endpackage

// File: rtl/wmi_mode_decode.sv
module wmi_mode_decode #(
  parameter int CLS_W      = 8,
  parameter int ADDR_W     = 6,
  parameter int LINE_W     = 7,
  parameter int WORD_BYTES = 4,
  parameter int CLS_SMALL  = 8,
  parameter int CLS_LARGE  = 16
) (
  input  logic              mwi_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [ADDR_W-1:0] addr_lo_i,
  input  logic              post_en_i,
  input  logic              alias_en_i,
  output logic [LINE_W-1:0] line_bytes_o,
  output logic              full_mwi_o
);
  localparam logic [LINE_W-1:0] LB_S   = LINE_W'(CLS_SMALL * WORD_BYTES);
  localparam logic [LINE_W-1:0] LB_L   = LINE_W'(CLS_LARGE * WORD_BYTES);
  localparam logic [ADDR_W-1:0] MASK_S = ADDR_W'(CLS_SMALL * WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] MASK_L = ADDR_W'(CLS_LARGE * WORD_BYTES - 1);

  logic is_small, is_large, cls_ok, aligned;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    is_small     = (cls_i == CLS_W'(CLS_SMALL));
    is_large     = (cls_i == CLS_W'(CLS_LARGE));
    cls_ok       = is_small | is_large;
    line_bytes_o = is_large ? LB_L : LB_S;
    mask         = is_large ? MASK_L : MASK_S;
    aligned      = (addr_lo_i & mask) == '0;
    // misaligned, aliased, unposted or bad size: plain write handling
    full_mwi_o   = mwi_i & cls_ok & post_en_i & ~alias_en_i & aligned;
  end
endmodule

// File: rtl/wmi_line_tracker.sv
module wmi_line_tracker #(
  parameter int LINE_W     = 7,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [LINE_W-1:0] line_o,
  output logic              boundary_o
);
  logic [LINE_W-1:0] off_q, line_q;

  function automatic logic [LINE_W-1:0] step(input logic [LINE_W-1:0] off,
                                             input logic [LINE_W-1:0] lb);
    logic [LINE_W:0] sum;
    sum = {1'b0, off} + (LINE_W+1)'(WORD_BYTES);
    return (sum >= {1'b0, lb}) ? '0 : sum[LINE_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      line_q <= '0;
    end else if (load_i) begin
      line_q <= line_i;
      off_q  <= step('0, line_i);
    end else if (adv_i) begin
      off_q  <= step(off_q, line_q);
    end
  end

  assign line_o     = line_q;
  assign boundary_o = (off_q == '0);

  a_r2_off_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q != '0) |-> (off_q < line_q));
endmodule

// File: rtl/wmi_admit.sv
module wmi_admit #(
  parameter int CLS_W      = 8,
  parameter int ADDR_W     = 6,
  parameter int FREE_W     = 10,
  parameter int WORD_BYTES = 4,
  parameter int CLS_SMALL  = 8,
  parameter int CLS_LARGE  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phase_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              mwi_i,
  input  logic [ADDR_W-1:0] addr_lo_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [FREE_W-1:0] free_bytes_i,
  input  logic              q_full_i,
  input  logic              post_en_i,
  input  logic              alias_en_i,
  input  logic              tgt_disc_i,
  input  logic              mabort_i,
  output logic              accept_o,
  output logic              retry_o,
  output logic              disc_o,
  output logic [1:0]        out_cmd_o
);
  import wmi_pkg::*;

  localparam int LINE_W = ADDR_W + 1;

  logic [LINE_W-1:0] line_now, line_cur;
  logic full_mwi, boundary, load, adv;
  logic room_new, room_line;

  logic active_q, mode_q, single_q, abort_q, rest_q;
  logic active_n, mode_n, single_n, abort_n, rest_n;
  logic acc_n, rty_n, dsc_n;
  out_cmd_e cmd_n, cmd_q;

  wmi_mode_decode #(
    .CLS_W(CLS_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .WORD_BYTES(WORD_BYTES),
    .CLS_SMALL(CLS_SMALL), .CLS_LARGE(CLS_LARGE)
  ) u_dec (
    .mwi_i(mwi_i), .cls_i(cls_i), .addr_lo_i(addr_lo_i),
    .post_en_i(post_en_i), .alias_en_i(alias_en_i),
    .line_bytes_o(line_now), .full_mwi_o(full_mwi)
  );

  wmi_line_tracker #(.LINE_W(LINE_W), .WORD_BYTES(WORD_BYTES)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .adv_i(adv),
    .line_i(line_now), .line_o(line_cur), .boundary_o(boundary)
  );

  assign room_new  = free_bytes_i >= FREE_W'(line_now);
  assign room_line = free_bytes_i >= FREE_W'(line_cur);

  always_comb begin
    active_n = active_q;
    mode_n   = mode_q;
    single_n = single_q;
    abort_n  = abort_q;
    rest_n   = rest_q;
    acc_n    = 1'b0;
    rty_n    = 1'b0;
    dsc_n    = 1'b0;
    cmd_n    = CMD_NONE;
    load     = 1'b0;
    adv      = 1'b0;
    if (phase_i) begin
      if (start_i) begin
        abort_n  = 1'b0;
        rest_n   = 1'b0;
        single_n = 1'b0;
        if (full_mwi) begin
          if (room_new) begin
            acc_n = 1'b1; cmd_n = CMD_MWI;
            active_n = 1'b1; mode_n = 1'b1; load = 1'b1;
          end else begin
            rty_n = 1'b1; active_n = 1'b0;
          end
        end else if (q_full_i) begin
          rty_n = 1'b1; active_n = 1'b0;
        end else begin
          acc_n = 1'b1; cmd_n = CMD_MW;
          active_n = 1'b1; mode_n = 1'b0; single_n = ~post_en_i;
        end
      end else if (active_q) begin
        if (abort_q) begin
          dsc_n = 1'b1; active_n = 1'b0;
        end else if (!mode_q) begin
          if (single_q || q_full_i) begin
            dsc_n = 1'b1; active_n = 1'b0;
          end else begin
            acc_n = 1'b1; cmd_n = CMD_MW;
          end
        end else if (boundary && !room_line) begin
          dsc_n = 1'b1; active_n = 1'b0;
        end else begin
          acc_n = 1'b1; adv = 1'b1;
          cmd_n = (rest_q && !boundary) ? CMD_MW : CMD_MWI;
          if (boundary) rest_n = 1'b0;
        end
      end
    end
    if (end_i) active_n = 1'b0;
    if (mabort_i && active_n) abort_n = 1'b1;
    // outbound disconnect mid-line: remainder of this line goes as memory write
    if (tgt_disc_i && active_n && mode_n && !boundary) rest_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; mode_q <= 1'b0; single_q <= 1'b0;
      abort_q  <= 1'b0; rest_q <= 1'b0;
      accept_o <= 1'b0; retry_o <= 1'b0; disc_o <= 1'b0;
      cmd_q    <= CMD_NONE;
    end else begin
      active_q <= active_n; mode_q <= mode_n; single_q <= single_n;
      abort_q  <= abort_n;  rest_q <= rest_n;
      accept_o <= acc_n; retry_o <= rty_n; disc_o <= dsc_n;
      cmd_q    <= cmd_n;
    end
  end

  assign out_cmd_o = cmd_q;

  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({accept_o, retry_o, disc_o}));
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i |=> (!accept_o && !retry_o && !disc_o && out_cmd_o == 2'd0));
  a_r11_cmd_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o == (out_cmd_o != 2'd0));
  a_r3_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && start_i && cls_i != CLS_W'(CLS_SMALL) && cls_i != CLS_W'(CLS_LARGE))
      |=> (out_cmd_o != 2'd2));
  a_r4_no_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && start_i && !post_en_i) |=> (out_cmd_o != 2'd2));
  a_r5_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && start_i && alias_en_i) |=> (out_cmd_o != 2'd2));
  a_r10_full_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && start_i && q_full_i && !mwi_i) |=> retry_o);
endmodule

// File: tb/tb_wmi_admit.sv
`timescale 1ns/1ps
module tb_wmi_admit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ph = 0, st = 0, en = 0, mwi = 0, q_full = 0, post = 1, alias_en = 0;
  logic td = 0, ma = 0;
  logic [5:0] addr = '0;
  logic [7:0] cls = 8'd8;
  logic [9:0] free_b = '0;
  logic acc, rty, dsc;
  logic [1:0] cmd;
  int n_tests = 0, n_fail = 0;

  // bench model state
  bit m_active, m_mode, m_single, m_abort, m_rest;
  int m_off, m_line;
  bit e_acc, e_rty, e_dsc;
  int e_cmd;

  always #10 clk = ~clk;

  wmi_admit dut (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(ph), .start_i(st), .end_i(en),
    .mwi_i(mwi), .addr_lo_i(addr), .cls_i(cls), .free_bytes_i(free_b),
    .q_full_i(q_full), .post_en_i(post), .alias_en_i(alias_en),
    .tgt_disc_i(td), .mabort_i(ma),
    .accept_o(acc), .retry_o(rty), .disc_o(dsc), .out_cmd_o(cmd)
  );

  function automatic int line_of(input logic [7:0] c);
    return (c == 8'd16) ? 64 : 32;
  endfunction

  function automatic bit qualifies();
    bit ok;
    ok = (cls == 8'd8) || (cls == 8'd16);
    return mwi && ok && post && !alias_en && ((int'(addr) % line_of(cls)) == 0);
  endfunction

  task automatic model();
    bit bnd;
    bnd = (m_off == 0);
    e_acc = 0; e_rty = 0; e_dsc = 0; e_cmd = 0;
    if (ph) begin
      if (st) begin
        m_abort = 0; m_rest = 0; m_single = 0;
        if (qualifies()) begin
          if (int'(free_b) >= line_of(cls)) begin
            e_acc = 1; e_cmd = 2; m_active = 1; m_mode = 1;
            m_line = line_of(cls); m_off = 4 % m_line;
          end else begin
            e_rty = 1; m_active = 0;
          end
        end else if (q_full) begin
          e_rty = 1; m_active = 0;
        end else begin
          e_acc = 1; e_cmd = 1; m_active = 1; m_mode = 0; m_single = !post;
        end
      end else if (m_active) begin
        if (m_abort) begin e_dsc = 1; m_active = 0; end
        else if (!m_mode) begin
          if (m_single || q_full) begin e_dsc = 1; m_active = 0; end
          else begin e_acc = 1; e_cmd = 1; end
        end else if (bnd && int'(free_b) < m_line) begin
          e_dsc = 1; m_active = 0;
        end else begin
          e_acc = 1;
          e_cmd = (m_rest && !bnd) ? 1 : 2;
          if (bnd) m_rest = 0;
          m_off = (m_off + 4) % m_line;
        end
      end
    end
    if (en) m_active = 0;
    if (ma && m_active) m_abort = 1;
    if (td && m_active && m_mode && bnd) m_rest = m_rest;
    else if (td && m_active && m_mode) m_rest = 1;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit p, input bit s, input bit e, input bit t,
                     input bit m, input string tag);
    @(negedge clk);
    ph = p; st = s; en = e; td = t; ma = m;
    model();
    @(posedge clk);
    #1;
    check({acc, rty, dsc} == {e_acc, e_rty, e_dsc}, tag, "resp",
          int'({acc, rty, dsc}), int'({e_acc, e_rty, e_dsc}));
    check(int'(cmd) == e_cmd, tag, "cmd", int'(cmd), e_cmd);
  endtask

  task automatic set_cfg(input bit w, input logic [7:0] c, input logic [5:0] a,
                         input int fr, input bit fu, input bit p, input bit al);
    mwi = w; cls = c; addr = a; free_b = 10'(fr); q_full = fu; post = p; alias_en = al;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog R11: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    int r;
    seed = 32'h5eed_1234;
    r = $urandom(seed);
    m_active = 0; m_mode = 0; m_single = 0; m_abort = 0; m_rest = 0; m_off = 0; m_line = 32;
    #1;
    check({acc, rty, dsc} == 3'b000 && cmd == 2'd0, "R11", "reset", int'({acc, rty, dsc, cmd}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, "R11");

    // R1 + R2: full MWI, line of 32 bytes, then short space at boundary
    set_cfg(1, 8, 0, 64, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, "R1");
    for (int i = 0; i < 7; i++) begin free_b = 0; cyc(1, 0, 0, 0, 0, "R2"); end
    free_b = 24;
    cyc(1, 0, 0, 0, 0, "R2");
    // R1 retry on short space
    set_cfg(1, 16, 0, 48, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, "R1");
    // R2 continue into a second line with room
    set_cfg(1, 8, 0, 32, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, "R2");
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 1, 0, 0, "R2");
    // R3 bad sizes
    set_cfg(1, 0, 0, 200, 0, 1, 0);  cyc(1, 1, 0, 0, 0, "R3"); cyc(1, 0, 1, 0, 0, "R3");
    set_cfg(1, 12, 0, 200, 0, 1, 0); cyc(1, 1, 1, 0, 0, "R3");
    // R4 posting disabled: single phase
    set_cfg(1, 8, 0, 200, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, "R4"); cyc(1, 0, 0, 0, 0, "R4");
    // R5 alias: no space needed
    set_cfg(1, 8, 0, 0, 0, 1, 1);  cyc(1, 1, 0, 0, 0, "R5"); cyc(1, 0, 1, 0, 0, "R5");
    set_cfg(1, 8, 0, 0, 1, 1, 1);  cyc(1, 1, 0, 0, 0, "R5");
    // R6 misaligned
    set_cfg(1, 8, 8, 200, 0, 1, 0); cyc(1, 1, 0, 0, 0, "R6"); cyc(1, 0, 1, 0, 0, "R6");
    // R7 initiator end mid line, then stray phase ignored
    set_cfg(1, 8, 0, 64, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, "R7"); cyc(1, 0, 0, 0, 0, "R7"); cyc(1, 0, 1, 0, 0, "R7");
    cyc(1, 0, 0, 0, 0, "R7");
    // R8 target disconnect mid line
    set_cfg(1, 8, 0, 64, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, "R8"); cyc(1, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 0, "R8");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, 0, "R8"); cyc(1, 0, 1, 0, 0, "R8");
    // R9 master abort
    set_cfg(1, 16, 0, 64, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, "R9"); cyc(0, 0, 0, 0, 1, "R9"); cyc(1, 0, 0, 0, 0, "R9");
    // R10 plain writes
    set_cfg(0, 8, 3, 0, 1, 1, 0); cyc(1, 1, 0, 0, 0, "R10");
    q_full = 0; cyc(1, 1, 0, 0, 0, "R10"); cyc(1, 0, 0, 0, 0, "R10");
    q_full = 1; cyc(1, 0, 0, 0, 0, "R10");

    // constrained random transactions
    for (int t = 0; t < 400; t++) begin
      int frees[7] = '{0, 24, 31, 32, 63, 64, 300};
      int len;
      set_cfg(($urandom % 4) != 0,
              (($urandom % 5) == 0) ? 8'($urandom % 20) : ((($urandom % 2) == 0) ? 8'd8 : 8'd16),
              (($urandom % 4) == 0) ? 6'($urandom) : 6'd0,
              frees[$urandom % 7], ($urandom % 6) == 0,
              ($urandom % 6) != 0, ($urandom % 6) == 0);
      cyc(1, 1, 0, 0, 0, "R1");
      len = $urandom % 24;
      for (int k = 0; k < len; k++) begin
        free_b = 10'(frees[$urandom % 7]);
        q_full = (free_b == 0) && ($urandom % 2 == 0);
        case ($urandom % 10)
          0: cyc(0, 0, 0, 1, 0, "R8");
          1: cyc(0, 0, 0, 0, ($urandom % 3) == 0, "R9");
          2: cyc(0, 0, 0, 0, 0, "R11");
          default: cyc(1, 0, 0, 0, 0, "R2");
        endcase
      end
      cyc(0, 0, 1, 0, 0, "R7");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule